// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block combines the reset requests that arise inside a small microcontroller into one system reset pulse of fixed length. Three internal requests can start a pulse, and each is qualified by its own condition. The first is a software write of the reset bit, which counts only while the main clock drives the CPU and the main oscillator is flagged stable. The second is a watchdog underflow, which counts only while the watchdog reset enable is set. The third is a main oscillator stop, which resets the chip when the stop mode bit is 0 and raises an interrupt instead when that bit is 1. An active-low external reset also drives the pulse and clears everything.

Across an internal reset, a two-bit processor mode field and one retained register keep their values. A register file returns to zero. When the pulse ends, the 20-bit start address is taken from the vector word at the top of memory and handed to the core together with a one-cycle start strobe. Four cause flags record which sources brought about the most recent reset. Software clears these flags by writing 1 to them.

Top module: `rstctl_top`

## Requirements
- R1: A software reset request (`sw_rst_wr` high) starts a pulse only when `main_clk_sel` and `main_osc_stable` are both 1 in that cycle. Otherwise the request is ignored: no pulse starts and no flag is set.
- R2: A watchdog underflow starts a pulse only when `wdt_rst_en` is 1. With the enable at 0 it has no effect.
- R3: An oscillator stop with `osc_stop_mode` = 0 starts a pulse. With `osc_stop_mode` = 1 no pulse starts, and `osc_irq` is high in the following cycle.
- R4: `sys_rst` rises in the cycle after an accepted request and stays high for exactly PULSE_LEN (default 16) cycles. Requests that arrive while it is high neither extend the pulse nor change the flags.
- R5: Requests accepted in the same cycle produce one pulse, and every matching cause flag is set.
- R6: `cause` bit 0 = software, bit 1 = watchdog, bit 2 = oscillator stop, bit 3 = external. An internal reset replaces the flags with its own sources. An external reset sets them to 4'b1000. Writing 1 to a bit of `cause_clr` clears that flag.
- R7: `mode_q` keeps its value across internal resets and is cleared to 0 by the external reset. Writes via `mode_wr` are ignored while `sys_rst` is high and in the cycle a request is accepted.
- R8: `ret_q` keeps its value across internal resets and is cleared by the external reset.
- R9: Every register file entry reads 0 from the first pulse cycle until it is written again. Writes during the pulse are ignored.
- R10: In the first cycle after `sys_rst` falls, `boot_go` is high for one cycle and `start_pc` equals `vec_word`. `vec_word` holds the low 20 bits of the three top-of-memory vector bytes, with the lowest address in bits 7:0.
- R11: While `ext_rst_n` is low, `sys_rst` is high. After its release, `sys_rst` stays high for PULSE_LEN more cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| ext_rst_n | input | 1 | External reset, active low, asynchronous assert |
| sw_rst_wr | input | 1 | Write of 1 to the software reset bit |
| main_clk_sel | input | 1 | Main clock is the CPU clock |
| main_osc_stable | input | 1 | Main oscillation is stable |
| wdt_underflow | input | 1 | Watchdog underflow event |
| wdt_rst_en | input | 1 | Watchdog underflow resets the chip |
| osc_stop_det | input | 1 | Main oscillator stop detected |
| osc_stop_mode | input | 1 | 0: stop resets, 1: stop interrupts |
| mode_wr | input | 1 | Processor mode write strobe |
| mode_wdata | input | MODE_W | Processor mode write data |
| ret_wr | input | 1 | Retained register write strobe |
| ret_wdata | input | DW | Retained register write data |
| rf_we | input | 1 | Register file write strobe |
| rf_waddr | input | AW | Register file write index |
| rf_wdata | input | DW | Register file write data |
| rf_raddr | input | AW | Register file read index |
| cause_clr | input | 4 | Write-1-to-clear for cause flags |
| vec_word | input | VEC_W | Reset vector word from top of memory |
| sys_rst | output | 1 | System reset pulse, active high |
| osc_irq | output | 1 | Oscillator stop interrupt request |
| cause | output | 4 | Reset cause flags |
| mode_q | output | MODE_W | Processor mode field |
| ret_q | output | DW | Retained register |
| rf_rdata | output | DW | Register file read data |
| start_pc | output | VEC_W | Start address captured at pulse end |
| boot_go | output | 1 | One-cycle start strobe to the core |

## Verification
The gating properties assume that a request which should be ignored arrives alone, with the other two sources quiet and no pulse running. The bench therefore raises each blocked request by itself, outside any pulse. Every stimulus change is held for exactly one clock and made at the falling edge. This means every accepted request becomes a single clean trigger. It also means a request placed inside a pulse never coincides with that pulse's own start cycle.

// File: rtl/rstctl_pkg.sv
package rstctl_pkg;

   // cause flag positions
   localparam int unsigned CAUSE_SW  = 0;
   localparam int unsigned CAUSE_WDT = 1;
   localparam int unsigned CAUSE_OSC = 2;
   localparam int unsigned CAUSE_EXT = 3;
   localparam int unsigned N_CAUSE   = 4;
   localparam int unsigned N_INT_SRC = 3;

   typedef logic [N_CAUSE-1:0]   cause_t;
   typedef logic [N_INT_SRC-1:0] hits_t;

   localparam cause_t CAUSE_EXT_ONLY = cause_t'(1) << CAUSE_EXT;

endpackage

// File: rtl/rstctl_gate.sv
module rstctl_gate
   import rstctl_pkg::*;
(
   input  logic  clk,
   input  logic  ext_rst_n,
   input  logic  sw_rst_wr,
   input  logic  main_clk_sel,
   input  logic  main_osc_stable,
   input  logic  wdt_underflow,
   input  logic  wdt_rst_en,
   input  logic  osc_stop_det,
   input  logic  osc_stop_mode,
   output hits_t hits,
   output logic  osc_irq
);

   logic sw_ok;

   // software write is honoured only on a stable main clock
   assign sw_ok = main_clk_sel & main_osc_stable;

   always_comb begin
      hits            = '0;
      hits[CAUSE_SW]  = sw_rst_wr & sw_ok;
      hits[CAUSE_WDT] = wdt_underflow & wdt_rst_en;
      hits[CAUSE_OSC] = osc_stop_det & ~osc_stop_mode;
   end

   always_ff @(posedge clk or negedge ext_rst_n) begin
      if (!ext_rst_n) osc_irq <= 1'b0;
      else            osc_irq <= osc_stop_det & osc_stop_mode;
   end

   // oscillator stop in interrupt mode never counts as a reset source
   p_irq_no_hit_r3: assert property (@(posedge clk) disable iff (!ext_rst_n)
      (osc_stop_det && osc_stop_mode) |-> !hits[CAUSE_OSC]);

endmodule

// File: rtl/rstctl_pulse.sv
module rstctl_pulse #(
   parameter int unsigned PULSE_LEN = 16
) (
   input  logic clk,
   input  logic ext_rst_n,
   input  logic trig,
   output logic busy,
   output logic start,
   output logic last
);

   localparam int unsigned CW = $clog2(PULSE_LEN + 1);

   if (PULSE_LEN < 2) begin : g_bad_len
      $error("rstctl_pulse: PULSE_LEN must be at least 2");
   end

   logic [CW-1:0] cnt;

   assign busy  = (cnt != '0);
   assign start = trig & ~busy;
   assign last  = (cnt == CW'(1));

   always_ff @(posedge clk or negedge ext_rst_n) begin
      if (!ext_rst_n)  cnt <= CW'(PULSE_LEN);
      else if (start)  cnt <= CW'(PULSE_LEN);
      else if (busy)   cnt <= cnt - CW'(1);
   end

   // independent length monitor
   logic [CW-1:0] hi_cnt;
   always_ff @(posedge clk or negedge ext_rst_n) begin
      if (!ext_rst_n) hi_cnt <= '0;
      else if (busy)  hi_cnt <= hi_cnt + CW'(1);
      else            hi_cnt <= '0;
   end

   p_pulse_len_r4: assert property (@(posedge clk) disable iff (!ext_rst_n)
      $fell(busy) |-> (hi_cnt == CW'(PULSE_LEN)));

   p_no_extend_r4: assert property (@(posedge clk) disable iff (!ext_rst_n)
      (busy && trig) |=> (cnt == $past(cnt) - CW'(1)));

endmodule

// File: rtl/rstctl_state.sv
module rstctl_state
   import rstctl_pkg::*;
#(
   parameter int unsigned DW     = 16,
   parameter int unsigned NREG   = 8,
   parameter int unsigned AW     = 3,
   parameter int unsigned MODE_W = 2,
   parameter int unsigned VEC_W  = 20
) (
   input  logic              clk,
   input  logic              ext_rst_n,
   input  logic              busy,
   input  logic              start,
   input  logic              last,
   input  hits_t             hits,
   input  logic              mode_wr,
   input  logic [MODE_W-1:0] mode_wdata,
   input  logic              ret_wr,
   input  logic [DW-1:0]     ret_wdata,
   input  logic              rf_we,
   input  logic [AW-1:0]     rf_waddr,
   input  logic [DW-1:0]     rf_wdata,
   input  logic [AW-1:0]     rf_raddr,
   input  cause_t            cause_clr,
   input  logic [VEC_W-1:0]  vec_word,
   output cause_t            cause,
   output logic [MODE_W-1:0] mode_q,
   output logic [DW-1:0]     ret_q,
   output logic [DW-1:0]     rf_rdata,
   output logic [VEC_W-1:0]  start_pc,
   output logic              boot_go
);

   localparam int unsigned RF_BITS = NREG * DW;

   if (NREG != (1 << AW)) begin : g_bad_depth
      $error("rstctl_state: NREG must equal 2**AW");
   end

   logic hold;
   assign hold = busy | start;

   // retained state: only the external reset touches it
   always_ff @(posedge clk or negedge ext_rst_n) begin
      if (!ext_rst_n) begin
         mode_q <= '0;
         ret_q  <= '0;
      end else if (!hold) begin
         if (mode_wr) mode_q <= mode_wdata;
         if (ret_wr)  ret_q  <= ret_wdata;
      end
   end

   // cause flags
   always_ff @(posedge clk or negedge ext_rst_n) begin
      if (!ext_rst_n) cause <= CAUSE_EXT_ONLY;
      else if (start) cause <= cause_t'(hits);
      else            cause <= cause & ~cause_clr;
   end

   // register file, cleared by any reset
   logic [RF_BITS-1:0] rf_flat;

   for (genvar i = 0; i < NREG; i++) begin : g_rf
      logic [DW-1:0] q;
      always_ff @(posedge clk or negedge ext_rst_n) begin
         if (!ext_rst_n)                          q <= '0;
         else if (hold)                           q <= '0;
         else if (rf_we && rf_waddr == AW'(i))    q <= rf_wdata;
      end
      assign rf_flat[i*DW +: DW] = q;
   end

   assign rf_rdata = rf_flat[rf_raddr*DW +: DW];

   // vector fetch at pulse end
   always_ff @(posedge clk or negedge ext_rst_n) begin
      if (!ext_rst_n) begin
         start_pc <= '0;
         boot_go  <= 1'b0;
      end else begin
         boot_go <= last;
         if (last) start_pc <= vec_word;
      end
   end

   p_mode_keep_r7: assert property (@(posedge clk) disable iff (!ext_rst_n)
      busy |=> $stable(mode_q));

   p_ret_keep_r8: assert property (@(posedge clk) disable iff (!ext_rst_n)
      busy |=> $stable(ret_q));

endmodule

// File: rtl/rstctl_top.sv
module rstctl_top
   import rstctl_pkg::*;
#(
   parameter int unsigned PULSE_LEN = 16,
   parameter int unsigned DW        = 16,
   parameter int unsigned NREG      = 8,
   parameter int unsigned AW        = $clog2(NREG),
   parameter int unsigned MODE_W    = 2,
   parameter int unsigned VEC_W     = 20
) (
   input  logic              clk,
   input  logic              ext_rst_n,
   input  logic              sw_rst_wr,
   input  logic              main_clk_sel,
   input  logic              main_osc_stable,
   input  logic              wdt_underflow,
   input  logic              wdt_rst_en,
   input  logic              osc_stop_det,
   input  logic              osc_stop_mode,
   input  logic              mode_wr,
   input  logic [MODE_W-1:0] mode_wdata,
   input  logic              ret_wr,
   input  logic [DW-1:0]     ret_wdata,
   input  logic              rf_we,
   input  logic [AW-1:0]     rf_waddr,
   input  logic [DW-1:0]     rf_wdata,
   input  logic [AW-1:0]     rf_raddr,
   input  logic [3:0]        cause_clr,
   input  logic [VEC_W-1:0]  vec_word,
   output logic              sys_rst,
   output logic              osc_irq,
   output logic [3:0]        cause,
   output logic [MODE_W-1:0] mode_q,
   output logic [DW-1:0]     ret_q,
   output logic [DW-1:0]     rf_rdata,
   output logic [VEC_W-1:0]  start_pc,
   output logic              boot_go
);

   if (VEC_W > 24 || VEC_W < 1) begin : g_bad_vec
      $error("rstctl_top: VEC_W must fit in three bytes");
   end
   if (AW != $clog2(NREG)) begin : g_bad_aw
      $error("rstctl_top: AW must match NREG");
   end

   hits_t hits;
   logic  busy, start, last;

   rstctl_gate u_gate (
      .clk             (clk),
      .ext_rst_n       (ext_rst_n),
      .sw_rst_wr       (sw_rst_wr),
      .main_clk_sel    (main_clk_sel),
      .main_osc_stable (main_osc_stable),
      .wdt_underflow   (wdt_underflow),
      .wdt_rst_en      (wdt_rst_en),
      .osc_stop_det    (osc_stop_det),
      .osc_stop_mode   (osc_stop_mode),
      .hits            (hits),
      .osc_irq         (osc_irq)
   );

   rstctl_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
      .clk       (clk),
      .ext_rst_n (ext_rst_n),
      .trig      (|hits),
      .busy      (busy),
      .start     (start),
      .last      (last)
   );

   rstctl_state #(
      .DW(DW), .NREG(NREG), .AW(AW), .MODE_W(MODE_W), .VEC_W(VEC_W)
   ) u_state (
      .clk        (clk),
      .ext_rst_n  (ext_rst_n),
      .busy       (busy),
      .start      (start),
      .last       (last),
      .hits       (hits),
      .mode_wr    (mode_wr),
      .mode_wdata (mode_wdata),
      .ret_wr     (ret_wr),
      .ret_wdata  (ret_wdata),
      .rf_we      (rf_we),
      .rf_waddr   (rf_waddr),
      .rf_wdata   (rf_wdata),
      .rf_raddr   (rf_raddr),
      .cause_clr  (cause_clr),
      .vec_word   (vec_word),
      .cause      (cause),
      .mode_q     (mode_q),
      .ret_q      (ret_q),
      .rf_rdata   (rf_rdata),
      .start_pc   (start_pc),
      .boot_go    (boot_go)
   );

   assign sys_rst = busy | ~ext_rst_n;

   p_sw_gate_r1: assert property (@(posedge clk) disable iff (!ext_rst_n)
      (sw_rst_wr && !(main_clk_sel && main_osc_stable) && !wdt_underflow
       && !osc_stop_det && !sys_rst) |=> !sys_rst);

   p_wdt_gate_r2: assert property (@(posedge clk) disable iff (!ext_rst_n)
      (wdt_underflow && !wdt_rst_en && !sw_rst_wr && !osc_stop_det && !sys_rst)
      |=> !sys_rst);

   p_osc_irq_r3: assert property (@(posedge clk) disable iff (!ext_rst_n)
      (osc_stop_det && osc_stop_mode) |=> osc_irq);

   p_one_pulse_r5: assert property (@(posedge clk) disable iff (!ext_rst_n)
      (!sys_rst && (sw_rst_wr || wdt_underflow || osc_stop_det)
       && $countones(hits) > 1) |=> (sys_rst && $countones(cause) > 1));

   p_rf_zero_r9: assert property (@(posedge clk) disable iff (!ext_rst_n)
      sys_rst |-> (rf_rdata == '0));

   p_boot_r10: assert property (@(posedge clk) disable iff (!ext_rst_n)
      $fell(sys_rst) |-> boot_go);

   p_boot_quiet_r10: assert property (@(posedge clk) disable iff (!ext_rst_n)
      boot_go |-> !sys_rst);

endmodule

// File: tb/rstctl_top_tb.sv
module rstctl_top_tb;

   localparam int PLEN = 16;

   logic        clk = 1'b0;
   logic        ext_rst_n;
   logic        sw_rst_wr, main_clk_sel, main_osc_stable;
   logic        wdt_underflow, wdt_rst_en, osc_stop_det, osc_stop_mode;
   logic        mode_wr;
   logic [1:0]  mode_wdata;
   logic        ret_wr;
   logic [15:0] ret_wdata;
   logic        rf_we;
   logic [2:0]  rf_waddr, rf_raddr;
   logic [15:0] rf_wdata;
   logic [3:0]  cause_clr;
   logic [19:0] vec_word;
   logic        sys_rst, osc_irq, boot_go;
   logic [3:0]  cause;
   logic [1:0]  mode_q;
   logic [15:0] ret_q, rf_rdata;
   logic [19:0] start_pc;

   always #5 clk = ~clk;

   rstctl_top u_dut (
      .clk(clk), .ext_rst_n(ext_rst_n), .sw_rst_wr(sw_rst_wr),
      .main_clk_sel(main_clk_sel), .main_osc_stable(main_osc_stable),
      .wdt_underflow(wdt_underflow), .wdt_rst_en(wdt_rst_en),
      .osc_stop_det(osc_stop_det), .osc_stop_mode(osc_stop_mode),
      .mode_wr(mode_wr), .mode_wdata(mode_wdata), .ret_wr(ret_wr),
      .ret_wdata(ret_wdata), .rf_we(rf_we), .rf_waddr(rf_waddr),
      .rf_wdata(rf_wdata), .rf_raddr(rf_raddr), .cause_clr(cause_clr),
      .vec_word(vec_word), .sys_rst(sys_rst), .osc_irq(osc_irq),
      .cause(cause), .mode_q(mode_q), .ret_q(ret_q), .rf_rdata(rf_rdata),
      .start_pc(start_pc), .boot_go(boot_go)
   );

   // scoreboard
   typedef enum int {S_RST, S_IRQ, S_CAUSE, S_MODE, S_RET, S_RF, S_PC, S_BOOT, S_LIT} sel_e;
   typedef struct {
      sel_e        sel;
      logic [31:0] exp;
      logic [31:0] lit;
      string       tag;
   } item_t;

   item_t exp_q[$];
   int    nchk = 0;
   int    nerr = 0;
   bit    done = 0;

   task automatic push(sel_e s, logic [31:0] e, string tag, logic [31:0] lit = '0);
      item_t it;
      it.sel = s; it.exp = e; it.lit = lit; it.tag = tag;
      exp_q.push_back(it);
   endtask

   always @(negedge clk) begin
      #1;
      while (exp_q.size() > 0) begin
         item_t it;
         logic [31:0] got;
         it = exp_q.pop_front();
         case (it.sel)
            S_RST:   got = 32'(sys_rst);
            S_IRQ:   got = 32'(osc_irq);
            S_CAUSE: got = 32'(cause);
            S_MODE:  got = 32'(mode_q);
            S_RET:   got = 32'(ret_q);
            S_RF:    got = 32'(rf_rdata);
            S_PC:    got = 32'(start_pc);
            S_BOOT:  got = 32'(boot_go);
            default: got = it.lit;
         endcase
         nchk++;
         if (got !== it.exp) begin
            nerr++;
            $display("FAIL %s: got %0h expected %0h", it.tag, got, it.exp);
         end
      end
   end

   task automatic step();
      @(negedge clk);
   endtask

   task automatic idle();
      sw_rst_wr = 0; wdt_underflow = 0; osc_stop_det = 0;
      mode_wr = 0; ret_wr = 0; rf_we = 0; cause_clr = 0;
   endtask

   // count negedges with sys_rst high, ending on the first low one
   task automatic measure(output int n);
      n = 0;
      while (sys_rst === 1'b1 && n < 100) begin
         n++;
         step();
      end
   endtask

   task automatic after_pulse(string tag, logic [3:0] exp_cause);
      int n;
      measure(n);
      push(S_LIT, PLEN, {tag, " R4 pulse length"}, 32'(n));
      push(S_BOOT, 1, {tag, " R10 boot strobe"});
      push(S_PC, 32'h54321, {tag, " R10 start address"});
      push(S_CAUSE, 32'(exp_cause), {tag, " R6 cause flags"});
      step();
      push(S_BOOT, 0, {tag, " R10 boot strobe one cycle"});
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         nchk++; nerr++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
         $finish;
      end
   end

   initial begin
      int n;
      ext_rst_n = 0; idle();
      main_clk_sel = 1; main_osc_stable = 1; wdt_rst_en = 0; osc_stop_mode = 0;
      mode_wdata = 0; ret_wdata = 0; rf_waddr = 0; rf_wdata = 0; rf_raddr = 3;
      vec_word = 20'h54321;
      repeat (3) step();
      push(S_RST, 1, "R11 reset held");
      push(S_CAUSE, 4'b1000, "R6 external cause");
      push(S_MODE, 0, "R7 mode after external");
      push(S_RET, 0, "R8 retained after external");
      ext_rst_n = 1;
      after_pulse("R11 external release", 4'b1000);

      // load state
      mode_wr = 1; mode_wdata = 2'b10; ret_wr = 1; ret_wdata = 16'hBEEF;
      rf_we = 1; rf_waddr = 3; rf_wdata = 16'h1234; cause_clr = 4'b1000;
      step(); idle();
      push(S_MODE, 2, "R7 mode written");
      push(S_RET, 16'hBEEF, "R8 retained written");
      push(S_RF, 16'h1234, "R9 rf written");
      push(S_CAUSE, 0, "R6 write-1 clear");

      // R1 blocked: clock not main, then not stable
      main_clk_sel = 0; sw_rst_wr = 1; step(); idle();
      push(S_RST, 0, "R1 ignored off main clock");
      push(S_CAUSE, 0, "R1 no flag off main clock");
      main_clk_sel = 1; main_osc_stable = 0; sw_rst_wr = 1; step(); idle();
      push(S_RST, 0, "R1 ignored unstable");
      main_osc_stable = 1; step();

      // R1 accepted
      sw_rst_wr = 1; step(); idle();
      push(S_RF, 0, "R9 rf cleared at pulse start");
      after_pulse("R1 software", 4'b0001);
      push(S_MODE, 2, "R7 mode kept over software reset");
      push(S_RET, 16'hBEEF, "R8 retained kept over software reset");
      push(S_RF, 0, "R9 rf zero after reset");

      // R2
      wdt_underflow = 1; step(); idle();
      push(S_RST, 0, "R2 underflow ignored when disabled");
      wdt_rst_en = 1; wdt_underflow = 1; step(); idle();
      push(S_RST, 1, "R2 underflow resets");
      after_pulse("R2 watchdog", 4'b0010);
      wdt_rst_en = 0;

      // R3
      osc_stop_mode = 1; osc_stop_det = 1; step(); idle();
      push(S_RST, 0, "R3 no reset in interrupt mode");
      push(S_IRQ, 1, "R3 interrupt raised");
      step();
      push(S_IRQ, 0, "R3 interrupt drops");
      osc_stop_mode = 0; osc_stop_det = 1; step(); idle();
      push(S_IRQ, 0, "R3 no interrupt in reset mode");
      after_pulse("R3 oscillator stop", 4'b0100);

      // R5 simultaneous
      wdt_rst_en = 1; sw_rst_wr = 1; wdt_underflow = 1; step(); idle();
      after_pulse("R5 simultaneous", 4'b0011);
      step();
      push(S_RST, 0, "R5 single pulse only");
      cause_clr = 4'b0001; step(); idle();
      push(S_CAUSE, 4'b0010, "R6 partial clear");

      // R4 / R7 / R9 during pulse
      sw_rst_wr = 1; step(); idle();
      repeat (4) step();
      wdt_underflow = 1; mode_wr = 1; mode_wdata = 2'b01;
      rf_we = 1; rf_waddr = 3; rf_wdata = 16'hAAAA;
      step(); idle();
      push(S_MODE, 2, "R7 mode write ignored in pulse");
      push(S_RF, 0, "R9 rf write ignored in pulse");
      n = 5;
      while (sys_rst === 1'b1 && n < 100) begin n++; step(); end
      push(S_LIT, PLEN, "R4 pulse not extended", 32'(n));
      push(S_CAUSE, 4'b0001, "R4 late request sets no flag");

      // external reset clears retained state
      step();
      ext_rst_n = 0; step();
      push(S_MODE, 0, "R7 mode cleared by external");
      push(S_RET, 0, "R8 retained cleared by external");
      push(S_CAUSE, 4'b1000, "R6 external overwrites");
      ext_rst_n = 1;
      after_pulse("R11 second external", 4'b1000);

      repeat (3) step();
      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

endmodule